// File: doc/BRIEF.md
# Receive FIFO Rejection Filter

This block decides, one frame at a time, whether a valid received frame that no dedicated receive buffer has claimed is written into the receive FIFO. It holds one rejection filter setting and one rejection mask. The filter setting has three parts: a 2-bit channel field, an 11-bit frame ID and a 7-bit cycle code. The mask has 11 bits and applies to the frame ID. Both settings can be written only while the configuration-state input is high. Filter fields in the headers of the FIFO's own buffers are not inputs to this block, so they cannot affect the decision.

For each frame the caller presents the frame ID, the receiving channel, the 6-bit cycle counter, a valid strobe and a flag that says a dedicated buffer matched. One clock later the block raises a one-cycle accept strobe if the frame is to be stored. Rejection works on a match. A frame is rejected when its cycle falls outside the set chosen by the cycle code. Inside that set, it is rejected when its channel is blocked or when its frame ID equals the filter on every unmasked bit.

Top module: `rxfifo_rej_filter`

## Requirements
- R1: After reset the filter frame ID, the channel field, the cycle code and the mask are all zero, and `fifo_accept` is low. With these values only frame ID 0 is rejected.
- R2: While `cfg_state` is high, `flt_we` loads `flt_ch`, `flt_fid` and `flt_cyc`, and `msk_we` loads `msk_fid`. The new values govern frames presented from the next cycle on.
- R3: While `cfg_state` is low, `flt_we` and `msk_we` have no effect on later decisions.
- R4: `fifo_accept` is registered. It is high for exactly the one cycle after a cycle in which an accepted frame was presented, so back-to-back frames give back-to-back strobes.
- R5: A frame presented with `rx_buf_hit` high is never accepted.
- R6: No accept follows a cycle in which `rx_valid` is low.
- R7: The frame ID is rejected when, for every bit position where the mask bit is 0, the frame ID bit equals the filter bit. A mask bit of 1 excludes that bit from the comparison.
- R8: Channel field encoding, with `rx_chan_b` = 0 meaning channel A and 1 meaning channel B: 00 accepts both channels, 01 accepts B only, 10 accepts A only, 11 accepts neither.
- R9: For the cycle code, let k be the position of its highest set bit among bits 6..1, or k = 0 if none of those bits is set. The cycle set is every counter value c with c mod 2^k equal to the low k bits of the code. A frame whose cycle counter is outside this set is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_state | input | 1 | High while the controller is in a configuration state |
| flt_we | input | 1 | Write strobe for the filter setting |
| flt_ch | input | 2 | New channel field |
| flt_fid | input | 11 | New filter frame ID |
| flt_cyc | input | 7 | New cycle code |
| msk_we | input | 1 | Write strobe for the mask |
| msk_fid | input | 11 | New frame ID mask (1 = bit not compared) |
| rx_valid | input | 1 | A valid received frame is presented |
| rx_fid | input | 11 | Frame ID of the presented frame |
| rx_chan_b | input | 1 | Receiving channel (0 = A, 1 = B) |
| rx_cycle | input | 6 | Cycle counter value when the frame was received |
| rx_buf_hit | input | 1 | A dedicated receive buffer matched the frame |
| fifo_accept | output | 1 | One-cycle strobe: write the frame into the FIFO |

## Verification
The assertions assume that the frame inputs and the write inputs are stable around each rising edge and are driven to zero while reset is held, because several properties look one cycle back. They also assume that `rx_buf_hit` means something only together with `rx_valid`. The bench drives every input on the falling edge and holds all inputs low during reset. It changes the configuration only through the write ports, and it then sends frames that expose both the new setting and any write that should have been ignored.

// File: rtl/rxfifo_rf_pkg.sv
package rxfifo_rf_pkg;
  localparam int FID_W = 11;
  localparam int CYC_W = 7;
  localparam int CNT_W = CYC_W - 1;
  localparam int CH_W  = 2;

  typedef struct packed {
    logic [CH_W-1:0]  ch;
    logic [FID_W-1:0] fid;
    logic [CYC_W-1:0] cyc;
  } rej_flt_t;

  // Cycle set membership: the highest set code bit k gives a repetition of 2^k,
  // and the low k code bits give the base.
  function automatic logic cyc_in_set(input logic [CYC_W-1:0] code,
                                      input logic [CNT_W-1:0] cnt);
    logic [CNT_W-1:0] m;
    m = '0;
    for (int i = 1; i < CYC_W; i++)
      if (code[i]) m = CNT_W'((32'd1 << i) - 32'd1);
    return ((cnt ^ code[CNT_W-1:0]) & m) == '0;
  endfunction

  // The frame ID hits the filter when every compared (unmasked) bit is equal.
  function automatic logic fid_hit(input logic [FID_W-1:0] id,
                                   input logic [FID_W-1:0] flt,
                                   input logic [FID_W-1:0] msk);
    return ((id ^ flt) & ~msk) == '0;
  endfunction

  // ch[0] blocks channel A, ch[1] blocks channel B.
  function automatic logic ch_blocked(input logic [CH_W-1:0] ch, input logic on_b);
    return on_b ? ch[1] : ch[0];
  endfunction
endpackage

// File: rtl/rxfifo_rf_regs.sv
module rxfifo_rf_regs
  import rxfifo_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_state,
  input  logic             flt_we,
  input  rej_flt_t         flt_wdata,
  input  logic             msk_we,
  input  logic [FID_W-1:0] msk_wdata,
  output rej_flt_t         flt_q,
  output logic [FID_W-1:0] msk_q
);
  logic flt_load, msk_load;
  assign flt_load = flt_we & cfg_state;
  assign msk_load = msk_we & cfg_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= '0;
      msk_q <= '0;
    end else begin
      if (flt_load) flt_q <= flt_wdata;
      if (msk_load) msk_q <= msk_wdata;
    end
  end

  p_flt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_state |=> $stable(flt_q));
  p_msk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_state |=> $stable(msk_q));
  p_flt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_state && flt_we) |=> (flt_q == $past(flt_wdata)));
endmodule

// File: rtl/rxfifo_rf_match.sv
module rxfifo_rf_match
  import rxfifo_rf_pkg::*;
(
  input  rej_flt_t         flt,
  input  logic [FID_W-1:0] msk,
  input  logic [FID_W-1:0] rx_fid,
  input  logic             rx_chan_b,
  input  logic [CNT_W-1:0] rx_cycle,
  output logic             cyc_ok,
  output logic             fid_rej,
  output logic             ch_rej,
  output logic             pass
);
  assign cyc_ok  = cyc_in_set(flt.cyc, rx_cycle);
  assign fid_rej = fid_hit(rx_fid, flt.fid, msk);
  assign ch_rej  = ch_blocked(flt.ch, rx_chan_b);
  assign pass    = cyc_ok & ~fid_rej & ~ch_rej;
endmodule

// File: rtl/rxfifo_rej_filter.sv
module rxfifo_rej_filter
  import rxfifo_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_state,
  input  logic             flt_we,
  input  logic [CH_W-1:0]  flt_ch,
  input  logic [FID_W-1:0] flt_fid,
  input  logic [CYC_W-1:0] flt_cyc,
  input  logic             msk_we,
  input  logic [FID_W-1:0] msk_fid,
  input  logic             rx_valid,
  input  logic [FID_W-1:0] rx_fid,
  input  logic             rx_chan_b,
  input  logic [CNT_W-1:0] rx_cycle,
  input  logic             rx_buf_hit,
  output logic             fifo_accept
);
  rej_flt_t         flt_wdata, flt_q;
  logic [FID_W-1:0] msk_q;
  logic             cyc_ok, fid_rej, ch_rej, pass, take;

  assign flt_wdata = '{ch: flt_ch, fid: flt_fid, cyc: flt_cyc};

  rxfifo_rf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_state(cfg_state),
    .flt_we(flt_we), .flt_wdata(flt_wdata),
    .msk_we(msk_we), .msk_wdata(msk_fid),
    .flt_q(flt_q), .msk_q(msk_q)
  );

  rxfifo_rf_match u_match (
    .flt(flt_q), .msk(msk_q), .rx_fid(rx_fid), .rx_chan_b(rx_chan_b),
    .rx_cycle(rx_cycle), .cyc_ok(cyc_ok), .fid_rej(fid_rej),
    .ch_rej(ch_rej), .pass(pass)
  );

  assign take = rx_valid & ~rx_buf_hit & pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fifo_accept <= 1'b0;
    else        fifo_accept <= take;
  end

  p_accept_needs_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_accept |-> $past(rx_valid));
  p_no_accept_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_accept |-> !$past(rx_buf_hit));
  p_accept_in_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_accept |-> $past(cyc_ok));
  p_fid_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fid_rej |=> !fifo_accept);
  p_ch_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ch_rej |=> !fifo_accept);
  p_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !fifo_accept);
endmodule

// File: tb/test_rxfifo_rej_filter.sv
module test_rxfifo_rej_filter;
  logic clk = 0, rst_n = 0;
  logic cfg_state = 0, flt_we = 0, msk_we = 0;
  logic [1:0] flt_ch = 0;
  logic [10:0] flt_fid = 0, msk_fid = 0, rx_fid = 0;
  logic [6:0] flt_cyc = 0;
  logic rx_valid = 0, rx_chan_b = 0, rx_buf_hit = 0;
  logic [5:0] rx_cycle = 0;
  logic fifo_accept;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  logic [1:0] m_ch = 0; logic [10:0] m_fid = 0, m_msk = 0; logic [6:0] m_cyc = 0;
  bit exp_acc = 0;
  string exp_tag = "R1";

  always #4 clk = ~clk;

  rxfifo_rej_filter i_rxfifo_rej_filter (.*);

  function automatic bit model_pass(input logic [10:0] id, input bit on_b, input int cyc);
    int rep, base;
    bit hit;
    rep = 1;
    for (int b = 6; b >= 1; b--) if (m_cyc[b] && rep == 1) rep = 1 << b;
    base = int'(m_cyc) % rep;
    if ((cyc % rep) != base) return 0;
    if (on_b && (m_ch == 2'b01 || m_ch == 2'b00)) hit = 0;
    else if (!on_b && (m_ch == 2'b10 || m_ch == 2'b00)) hit = 0;
    else hit = 1;
    if (hit) return 0;
    hit = 1;
    for (int b = 0; b < 11; b++) if (!m_msk[b] && id[b] != m_fid[b]) hit = 0;
    return !hit;
  endfunction

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s fifo_accept actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // One cycle: check the previous cycle's result, then drive new inputs.
  task automatic step(input string tag, input bit cfg, input bit fw, input logic [1:0] ch,
                      input logic [10:0] fid, input logic [6:0] cyc, input bit mw,
                      input logic [10:0] mk, input bit v, input logic [10:0] id,
                      input bit onb, input logic [5:0] cc, input bit hit);
    @(negedge clk);
    chk(fifo_accept, exp_acc, exp_tag);
    exp_acc = v && !hit && model_pass(id, onb, int'(cc));
    exp_tag = tag;
    if (cfg && fw) begin m_ch = ch; m_fid = fid; m_cyc = cyc; end
    if (cfg && mw) m_msk = mk;
    cfg_state = cfg; flt_we = fw; flt_ch = ch; flt_fid = fid; flt_cyc = cyc;
    msk_we = mw; msk_fid = mk; rx_valid = v; rx_fid = id; rx_chan_b = onb;
    rx_cycle = cc; rx_buf_hit = hit;
  endtask

  task automatic frame(input string tag, input logic [10:0] id, input bit onb,
                       input logic [5:0] cc, input bit hit);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 1, id, onb, cc, hit);
  endtask

  task automatic wflt(input bit cfg, input logic [1:0] ch, input logic [10:0] fid,
                      input logic [6:0] cyc);
    step(cfg ? "R2" : "R3", cfg, 1, ch, fid, cyc, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wmsk(input bit cfg, input logic [10:0] mk);
    step(cfg ? "R2" : "R3", cfg, 0, 0, 0, 0, 1, mk, 0, 0, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fifo_accept, 0, "R1");
    rst_n = 1;
    frame("R1", 11'd5, 0, 6'd3, 0);
    frame("R7", 11'd0, 1, 6'd9, 0);
    frame("R1", 11'd7, 1, 6'd63, 0);
    // cycle code 0000100: repetition 4, base 0
    wflt(1, 2'b00, 11'h123, 7'b0000100);
    frame("R7", 11'h123, 0, 6'd0, 0);
    frame("R2", 11'h124, 0, 6'd0, 0);
    frame("R9", 11'h124, 0, 6'd1, 0);
    frame("R9", 11'h124, 1, 6'd4, 0);
    // repetition 16, base 5
    wflt(1, 2'b00, 11'h123, 7'b0010101);
    frame("R9", 11'h200, 0, 6'd21, 0);
    frame("R9", 11'h200, 0, 6'd5, 0);
    frame("R9", 11'h200, 0, 6'd6, 0);
    frame("R9", 11'h200, 0, 6'd37, 0);
    wflt(1, 2'b00, 11'h123, 7'b0000001);
    wmsk(1, 11'h00F);
    frame("R7", 11'h12A, 0, 6'd8, 0);
    frame("R7", 11'h133, 0, 6'd8, 0);
    wmsk(0, 11'h7FF);
    frame("R3", 11'h133, 0, 6'd8, 0);
    wflt(0, 2'b11, 11'h133, 7'b1000000);
    frame("R3", 11'h155, 1, 6'd2, 0);
    wflt(1, 2'b01, 11'h000, 7'b0000000);
    wmsk(1, 11'h000);
    frame("R8", 11'h050, 0, 6'd2, 0);
    frame("R8", 11'h050, 1, 6'd2, 0);
    wflt(1, 2'b10, 11'h000, 7'b0000000);
    frame("R8", 11'h050, 0, 6'd2, 0);
    frame("R8", 11'h050, 1, 6'd2, 0);
    wflt(1, 2'b11, 11'h000, 7'b0000000);
    frame("R8", 11'h050, 0, 6'd2, 0);
    frame("R8", 11'h050, 1, 6'd2, 0);
    wflt(1, 2'b00, 11'h000, 7'b0000000);
    frame("R5", 11'h060, 0, 6'd2, 1);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 11'h060, 0, 6'd2, 0);
    frame("R4", 11'h061, 0, 6'd2, 0);
    frame("R4", 11'h062, 1, 6'd3, 0);
    frame("R4", 11'h063, 0, 6'd4, 0);
    step("R4", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int n = 0; n < 400; n++) begin
      bit cfg = ($urandom % 4) == 0;
      step("R4", cfg, ($urandom % 6) == 0, 2'($urandom), 11'($urandom % 8),
           7'($urandom), ($urandom % 6) == 0, 11'($urandom & 11'h7F0),
           ($urandom % 4) != 0, 11'($urandom % 8), 1'($urandom), 6'($urandom),
           ($urandom % 5) == 0);
    end
    step("R4", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(fifo_accept, exp_acc, exp_tag);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule